// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block holds two 16-bit address pointers for a small 8-bit CPU core. Each pointer is built from a low byte and a high byte. A one-bit select register picks which pointer is active. The active pointer drives a 16-bit address output, which the core uses for external data and code fetches. The core reads and writes the select register and all four pointer bytes as special-function registers over a byte-wide port. Reads are combinational on the address. Writes take effect on the next clock edge.

A separate operation port acts on the active pointer only. It can load a full 16-bit value, add one, or subtract one. The other pointer is left untouched. Switching pointers costs one register write, so block copies between two memory regions need no save and restore of the address. The decrement lets a loop walk down through memory as cheaply as it walks up.

Top module: `dual_addr_ptr`

## Requirements
- R1: After reset, both pointers and the select bit are 0, so `ptr_addr` is 0000h and every mapped register reads 00h.
- R2: The select register sits at address 86h. When its bit 0 is 1, `ptr_addr` shows the second pointer; when it is 0, `ptr_addr` shows the first. A select write takes effect on the next clock edge. The select register reads back its bit 0 in data bit 0.
- R3: Select bits 7..1 always read 0, and writing 1s to them changes nothing (writing FEh reads back 00h and leaves the first pointer active).
- R4: Pointer bytes map to these addresses: first pointer low 82h, first high 83h, second low 84h, second high 85h. A write updates that byte on the next edge, and a read returns it in the same cycle. `sfr_hit` is 1 for addresses 82h..86h.
- R5: An operation with `op_valid`=1 and `op_kind`=01 loads `op_data` into the active pointer on the next edge.
- R6: `op_kind`=10 adds 1 to the active pointer. The carry passes from the low byte into the high byte, and FFFFh wraps to 0000h.
- R7: `op_kind`=11 subtracts 1 from the active pointer. The borrow passes from the low byte into the high byte, and 0000h wraps to FFFFh.
- R8: The pointer that is not active keeps its value through every operation on the active one.
- R9: If an operation and a write to a byte of the active pointer land in the same cycle, the operation wins. A write to a byte of the inactive pointer in that cycle still takes effect.
- R10: An operation issued in the same cycle as a select write acts on the pointer that was active before that write.
- R11: Writes to addresses outside 82h..86h change nothing. Reads there return 00h with `sfr_hit`=0.
- R12: `op_valid`=0, or `op_kind`=00, is no operation: no pointer changes, and a same-cycle register write to any pointer byte still applies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address for reads and writes |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data, combinational on `sfr_addr` |
| sfr_hit | output | 1 | `sfr_addr` selects one of this unit's registers |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 00 none, 01 load, 10 increment, 11 decrement |
| op_data | input | 16 | Load value |
| ptr_addr | output | 16 | Active pointer value |

## Verification
The assertions assume that `op_kind`, `op_data`, `sfr_wr` and `sfr_addr` are stable across each rising edge and known while reset is released. The bench therefore drives every input just after a falling edge and never leaves one undefined. The hold and step properties also assume that the select register is not written in the cycle they examine, so each property excludes that case in its own antecedent. The stimulus then mixes every combination freely: a write to any address from 80h to 87h can coincide with any operation, including boundary loads of 0000h, 00FFh, FF00h and FFFFh.

// File: rtl/dap_pkg.sv
package dap_pkg;

   typedef enum logic [1:0] {
      DAP_NOP  = 2'b00,
      DAP_LOAD = 2'b01,
      DAP_INC  = 2'b10,
      DAP_DEC  = 2'b11
   } dap_op_e;

   function automatic bit dap_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/dap_step.sv
module dap_step #(
   parameter int WIDTH    = 16,
   parameter int BYTE_W   = 8,
   parameter bit BYTEWISE = 1'b1
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic             down_i,
   output logic [WIDTH-1:0] nxt_o
);
   localparam int NBYTES = WIDTH / BYTE_W;

   generate
      if (BYTEWISE) begin : g_chain
         logic [NBYTES-1:0] carry;
         assign carry[0] = 1'b1;
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            logic [BYTE_W-1:0] seg;
            assign seg = cur_i[b*BYTE_W +: BYTE_W];
            assign nxt_o[b*BYTE_W +: BYTE_W] = down_i ? seg - BYTE_W'(carry[b])
                                                      : seg + BYTE_W'(carry[b]);
            if (b < NBYTES - 1) begin : g_next
               assign carry[b+1] = carry[b] & (down_i ? (seg == '0) : (seg == '1));
            end
         end
      end else begin : g_flat
         assign nxt_o = down_i ? cur_i - WIDTH'(1) : cur_i + WIDTH'(1);
      end
   endgenerate

endmodule

// File: rtl/dap_ptr_reg.sv
module dap_ptr_reg
   import dap_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int BYTE_W   = 8,
   parameter bit BYTEWISE = 1'b1,
   localparam int NBYTES  = WIDTH / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_en_i,
   input  dap_op_e           op_kind_i,
   input  logic [WIDTH-1:0]  op_data_i,
   input  logic [NBYTES-1:0] byte_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [WIDTH-1:0]  q_o
);
   logic [WIDTH-1:0] stepped;

   dap_step #(
      .WIDTH    (WIDTH),
      .BYTE_W   (BYTE_W),
      .BYTEWISE (BYTEWISE)
   ) u_step (
      .cur_i  (q_o),
      .down_i (op_kind_i == DAP_DEC),
      .nxt_o  (stepped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (op_en_i) begin
         case (op_kind_i)
            DAP_LOAD:         q_o <= op_data_i;
            DAP_INC, DAP_DEC: q_o <= stepped;
            default:          q_o <= q_o;
         endcase
      end else begin
         for (int b = 0; b < NBYTES; b++) begin
            if (byte_we_i[b]) q_o[b*BYTE_W +: BYTE_W] <= wdata_i;
         end
      end
   end

endmodule

// File: rtl/dap_sfr_map.sv
module dap_sfr_map #(
   parameter int ADDR_W   = 8,
   parameter int BYTE_W   = 8,
   parameter int NUM_PTR  = 2,
   parameter int NBYTES   = 2,
   parameter int PTR_BASE = 'h82,
   parameter int SEL_ADDR = 'h86,
   parameter int SEL_W    = 1,
   localparam int NSLOTS  = NUM_PTR * NBYTES
) (
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     wr_i,
   input  logic [NSLOTS*BYTE_W-1:0] ptr_flat_i,
   input  logic [SEL_W-1:0]         sel_i,
   output logic [NSLOTS-1:0]        byte_we_o,
   output logic                     sel_we_o,
   output logic [BYTE_W-1:0]        rdata_o,
   output logic                     hit_o
);
   logic [NSLOTS-1:0] slot_hit;
   logic              sel_hit;

   generate
      for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
         assign slot_hit[s] = (addr_i == ADDR_W'(PTR_BASE + s));
      end
   endgenerate

   assign sel_hit   = (addr_i == ADDR_W'(SEL_ADDR));
   assign byte_we_o = slot_hit & {NSLOTS{wr_i}};
   assign sel_we_o  = sel_hit & wr_i;
   assign hit_o     = (|slot_hit) | sel_hit;

   always_comb begin
      rdata_o = '0;
      for (int s = 0; s < NSLOTS; s++) begin
         if (slot_hit[s]) rdata_o = rdata_o | ptr_flat_i[s*BYTE_W +: BYTE_W];
      end
      if (sel_hit) rdata_o = rdata_o | BYTE_W'(sel_i);
   end

endmodule

// File: rtl/dual_addr_ptr.sv
module dual_addr_ptr
   import dap_pkg::*;
#(
   parameter int PTR_W          = 16,
   parameter int BYTE_W         = 8,
   parameter int NUM_PTR        = 2,
   parameter int ADDR_W         = 8,
   parameter int PTR_BASE       = 'h82,
   parameter int SEL_ADDR       = 'h86,
   parameter bit BYTEWISE_STEP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_wr,
   input  logic [ADDR_W-1:0] sfr_addr,
   input  logic [BYTE_W-1:0] sfr_wdata,
   output logic [BYTE_W-1:0] sfr_rdata,
   output logic              sfr_hit,
   input  logic              op_valid,
   input  logic [1:0]        op_kind,
   input  logic [PTR_W-1:0]  op_data,
   output logic [PTR_W-1:0]  ptr_addr
);
   localparam int NBYTES = PTR_W / BYTE_W;
   localparam int SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
   localparam int NSLOTS = NUM_PTR * NBYTES;

   generate
      if (PTR_W % BYTE_W != 0) begin : g_bad_width
         $error("PTR_W must be a whole number of bytes");
      end
      if (NUM_PTR < 2 || !dap_is_pow2(NUM_PTR)) begin : g_bad_count
         $error("NUM_PTR must be a power of two, at least 2");
      end
      if (SEL_W > BYTE_W) begin : g_bad_sel
         $error("select field wider than a register byte");
      end
      if (PTR_BASE + NSLOTS > (1 << ADDR_W) || SEL_ADDR >= (1 << ADDR_W)) begin : g_bad_range
         $error("register addresses exceed the address space");
      end
      if (SEL_ADDR >= PTR_BASE && SEL_ADDR < PTR_BASE + NSLOTS) begin : g_bad_overlap
         $error("select address overlaps the pointer bytes");
      end
   endgenerate

   dap_op_e                   op_code;
   logic                      op_active;
   logic [SEL_W-1:0]          sel_q;
   logic                      sel_we;
   logic [NSLOTS-1:0]         byte_we;
   logic [NUM_PTR*PTR_W-1:0]  ptr_flat;

   assign op_code   = dap_op_e'(op_kind);
   assign op_active = op_valid && (op_code != DAP_NOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_we) sel_q <= sfr_wdata[SEL_W-1:0];
   end

   generate
      for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
         dap_ptr_reg #(
            .WIDTH    (PTR_W),
            .BYTE_W   (BYTE_W),
            .BYTEWISE (BYTEWISE_STEP)
         ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_en_i   (op_active && (sel_q == SEL_W'(k))),
            .op_kind_i (op_code),
            .op_data_i (op_data),
            .byte_we_i (byte_we[k*NBYTES +: NBYTES]),
            .wdata_i   (sfr_wdata),
            .q_o       (ptr_flat[k*PTR_W +: PTR_W])
         );
      end
   endgenerate

   always_comb begin
      ptr_addr = '0;
      for (int k = 0; k < NUM_PTR; k++) begin
         if (sel_q == SEL_W'(k)) ptr_addr = ptr_flat[k*PTR_W +: PTR_W];
      end
   end

   dap_sfr_map #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .NUM_PTR  (NUM_PTR),
      .NBYTES   (NBYTES),
      .PTR_BASE (PTR_BASE),
      .SEL_ADDR (SEL_ADDR),
      .SEL_W    (SEL_W)
   ) u_map (
      .addr_i     (sfr_addr),
      .wr_i       (sfr_wr),
      .ptr_flat_i (ptr_flat),
      .sel_i      (sel_q),
      .byte_we_o  (byte_we),
      .sel_we_o   (sel_we),
      .rdata_o    (sfr_rdata),
      .hit_o      (sfr_hit)
   );

endmodule

module dual_addr_ptr_chk #(
   parameter int PTR_W    = 16,
   parameter int BYTE_W   = 8,
   parameter int NUM_PTR  = 2,
   parameter int ADDR_W   = 8,
   parameter int PTR_BASE = 'h82,
   parameter int SEL_ADDR = 'h86,
   parameter int SEL_W    = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sfr_wr,
   input logic [ADDR_W-1:0]        sfr_addr,
   input logic [BYTE_W-1:0]        sfr_rdata,
   input logic                     sfr_hit,
   input logic                     op_valid,
   input logic [1:0]               op_kind,
   input logic [PTR_W-1:0]         op_data,
   input logic [PTR_W-1:0]         ptr_addr,
   input logic [SEL_W-1:0]         sel_q,
   input logic [NUM_PTR*PTR_W-1:0] ptr_flat
);
   localparam int SPAN = NUM_PTR * (PTR_W / BYTE_W);

   logic sel_wr;
   logic mapped;
   logic busy;

   assign sel_wr = sfr_wr && (sfr_addr == ADDR_W'(SEL_ADDR));
   assign mapped = (sfr_addr == ADDR_W'(SEL_ADDR)) ||
                   ((int'(sfr_addr) >= PTR_BASE) && (int'(sfr_addr) < PTR_BASE + SPAN));
   assign busy   = op_valid && (op_kind != 2'b00);

   assert_sel_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_addr == ADDR_W'(SEL_ADDR)) |-> (sfr_rdata[BYTE_W-1:SEL_W] == '0));

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'b01 && !sel_wr) |=> (ptr_addr == $past(op_data)));

   assert_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'b10 && !sel_wr) |=> (ptr_addr == PTR_W'($past(ptr_addr) + 1'b1)));

   assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'b11 && !sel_wr) |=> (ptr_addr == PTR_W'($past(ptr_addr) - 1'b1)));

   assert_op_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_kind == 2'b01 && sfr_wr && !sel_wr) |=> (ptr_addr == $past(op_data)));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !sfr_wr) |=> $stable(ptr_addr));

   assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (sfr_rdata == '0 && !sfr_hit));

   generate
      for (genvar k = 0; k < NUM_PTR; k++) begin : g_hold
         assert_inactive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (busy && !sfr_wr && sel_q != SEL_W'(k)) |=> $stable(ptr_flat[k*PTR_W +: PTR_W]));
      end
   endgenerate

endmodule

bind dual_addr_ptr dual_addr_ptr_chk #(
   .PTR_W    (PTR_W),
   .BYTE_W   (BYTE_W),
   .NUM_PTR  (NUM_PTR),
   .ADDR_W   (ADDR_W),
   .PTR_BASE (PTR_BASE),
   .SEL_ADDR (SEL_ADDR),
   .SEL_W    (SEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sfr_wr    (sfr_wr),
   .sfr_addr  (sfr_addr),
   .sfr_rdata (sfr_rdata),
   .sfr_hit   (sfr_hit),
   .op_valid  (op_valid),
   .op_kind   (op_kind),
   .op_data   (op_data),
   .ptr_addr  (ptr_addr),
   .sel_q     (sel_q),
   .ptr_flat  (ptr_flat)
);

// File: tb/dual_addr_ptr_test.sv
module dual_addr_ptr_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        sfr_hit;
   logic        op_valid = 1'b0;
   logic [1:0]  op_kind = 2'b00;
   logic [15:0] op_data = 16'h0000;
   logic [15:0] ptr_addr;

   int total = 0;
   int fails = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   int ref_p [2];
   int ref_sel;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_addr_ptr uut (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
      .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data), .ptr_addr(ptr_addr)
   );

   function automatic int ref_read(input int a);
      if (a == 'h86) return ref_sel;
      if (a >= 'h82 && a <= 'h85) return (ref_p[(a - 'h82) / 2] >> (8 * ((a - 'h82) % 2))) & 'hFF;
      return 0;
   endfunction

   // behavioural reference, updated at each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_p[0] = 0; ref_p[1] = 0; ref_sel = 0;
      end else begin
         int nsel;
         bit act;
         nsel = ref_sel;
         act = op_valid && (op_kind != 2'b00);
         if (act) begin
            case (op_kind)
               2'b01: ref_p[ref_sel] = int'(op_data);
               2'b10: ref_p[ref_sel] = (ref_p[ref_sel] + 1) % 65536;
               default: ref_p[ref_sel] = (ref_p[ref_sel] + 65535) % 65536;
            endcase
         end
         if (sfr_wr) begin
            int a;
            a = int'(sfr_addr);
            if (a == 'h86) nsel = int'(sfr_wdata) & 1;
            else if (a >= 'h82 && a <= 'h85) begin
               int k, sh;
               k = (a - 'h82) / 2;
               sh = 8 * ((a - 'h82) % 2);
               if (!(act && k == ref_sel))
                  ref_p[k] = (ref_p[k] & ~('hFF << sh)) | (int'(sfr_wdata) << sh);
            end
         end
         ref_sel = nsel;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R2 ptr_addr vs model", int'(ptr_addr), ref_p[ref_sel]);
         chk("R4 sfr_rdata vs model", int'(sfr_rdata), ref_read(int'(sfr_addr)));
         chk("R11 sfr_hit vs model", int'(sfr_hit),
             (sfr_addr >= 8'h82 && sfr_addr <= 8'h86) ? 1 : 0);
      end
   end

   task automatic cyc(input bit v, input logic [1:0] k, input logic [15:0] d,
                      input bit w, input logic [7:0] a, input logic [7:0] wd);
      #1;
      op_valid = v; op_kind = k; op_data = d;
      sfr_wr = w; sfr_addr = a; sfr_wdata = wd;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output int val);
      #1;
      op_valid = 1'b0; op_kind = 2'b00; sfr_wr = 1'b0; sfr_addr = a;
      #1;
      val = int'(sfr_rdata);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", total, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ptr_addr after reset", int'(ptr_addr), 'h0000);
      for (int a = 'h82; a <= 'h86; a++) begin
         rd(8'(a), v);
         chk("R1 register after reset", v, 0);
      end
      cmp_on = 1'b1;

      // R4 byte writes and readback
      cyc(0, 2'b00, 16'h0, 1, 8'h82, 8'h34);
      cyc(0, 2'b00, 16'h0, 1, 8'h83, 8'h12);
      rd(8'h82, v); chk("R4 first low byte", v, 'h34);
      rd(8'h83, v); chk("R4 first high byte", v, 'h12);
      chk("R2 first pointer active", int'(ptr_addr), 'h1234);
      cyc(0, 2'b00, 16'h0, 1, 8'h84, 8'hCD);
      cyc(0, 2'b00, 16'h0, 1, 8'h85, 8'hAB);
      chk("R4 inactive write keeps output", int'(ptr_addr), 'h1234);

      // R2 select
      cyc(0, 2'b00, 16'h0, 1, 8'h86, 8'h01);
      chk("R2 second pointer active", int'(ptr_addr), 'hABCD);
      rd(8'h86, v); chk("R2 select readback", v, 1);

      // R3 reserved bits
      cyc(0, 2'b00, 16'h0, 1, 8'h86, 8'hFE);
      rd(8'h86, v); chk("R3 reserved bits read 0", v, 0);
      chk("R3 first pointer active again", int'(ptr_addr), 'h1234);

      // R5, R6, R7 on first pointer
      cyc(1, 2'b01, 16'h00FF, 0, 8'h00, 8'h00);
      chk("R5 load", int'(ptr_addr), 'h00FF);
      cyc(1, 2'b10, 16'h0, 0, 8'h00, 8'h00);
      chk("R6 carry into high byte", int'(ptr_addr), 'h0100);
      cyc(1, 2'b01, 16'hFFFF, 0, 8'h00, 8'h00);
      cyc(1, 2'b10, 16'h0, 0, 8'h00, 8'h00);
      chk("R6 wrap FFFF to 0000", int'(ptr_addr), 'h0000);
      cyc(1, 2'b11, 16'h0, 0, 8'h00, 8'h00);
      chk("R7 wrap 0000 to FFFF", int'(ptr_addr), 'hFFFF);
      cyc(1, 2'b01, 16'h0100, 0, 8'h00, 8'h00);
      cyc(1, 2'b11, 16'h0, 0, 8'h00, 8'h00);
      chk("R7 borrow from high byte", int'(ptr_addr), 'h00FF);
      rd(8'h84, v); chk("R8 second low untouched", v, 'hCD);
      rd(8'h85, v); chk("R8 second high untouched", v, 'hAB);

      // R9 operation against same-cycle writes
      cyc(1, 2'b10, 16'h0, 1, 8'h82, 8'h55);
      chk("R9 op beats active write", int'(ptr_addr), 'h0100);
      cyc(1, 2'b10, 16'h0, 1, 8'h84, 8'h77);
      chk("R9 op applied", int'(ptr_addr), 'h0101);
      rd(8'h84, v); chk("R9 inactive write applied", v, 'h77);

      // R10 select write alongside an operation
      cyc(1, 2'b01, 16'h4444, 1, 8'h86, 8'h01);
      chk("R10 new select next cycle", int'(ptr_addr), 'hAB77);
      rd(8'h82, v); chk("R10 op hit old pointer low", v, 'h44);
      rd(8'h83, v); chk("R10 op hit old pointer high", v, 'h44);
      cyc(1, 2'b11, 16'h0, 0, 8'h00, 8'h00);
      chk("R7 decrement second pointer", int'(ptr_addr), 'hAB76);
      rd(8'h82, v); chk("R8 first pointer untouched", v, 'h44);

      // R11 unmapped addresses
      cyc(0, 2'b00, 16'h0, 1, 8'h80, 8'hAA);
      rd(8'h80, v); chk("R11 unmapped read", v, 0);
      chk("R11 unmapped hit", int'(sfr_hit), 0);
      rd(8'h87, v); chk("R11 unmapped read 87h", v, 0);
      chk("R11 pointer unchanged", int'(ptr_addr), 'hAB76);

      // R12 no-operation encodings
      cyc(1, 2'b00, 16'h0, 1, 8'h85, 8'h11);
      chk("R12 code 00 lets write through", int'(ptr_addr), 'h1176);
      cyc(0, 2'b10, 16'h0, 0, 8'h00, 8'h00);
      chk("R12 op_valid low ignored", int'(ptr_addr), 'h1176);

      // mixed traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] d;
         case ($urandom % 6)
            0: d = 16'h0000;
            1: d = 16'hFFFF;
            2: d = 16'h00FF;
            3: d = 16'hFF00;
            default: d = 16'($urandom);
         endcase
         cyc(1'($urandom % 2), 2'($urandom), d, ($urandom % 3) == 0,
             8'h80 + 8'($urandom % 8), 8'($urandom));
      end

      finish_run();
   end
endmodule